// File: doc/BRIEF.md
# RC4 Keystream Generator

This core turns a secret key of one to sixteen bytes into an RC4 keystream. The 256-entry permutation table sits in an internal memory that has three ports: a read-only port, a write-only port and a read/write port. Each permutation step reads the table, computes a new index and swaps two entries. These three operations are spread over the ports so that one iteration finishes every two clock cycles.

A pulse on the load input captures the key and its length. The core then fills the table with the identity permutation. It mixes the key into the table and starts producing keystream bytes with no further command. Bytes leave through a valid/ready output with a one-byte holding register. While that register is full and not being taken, the generator waits. Combining the keystream with data is left to the surrounding logic.

Top module: `rc4_keystream_core`

## Requirements
- R1: After reset, and until a key is loaded, `ks_valid` stays low whatever `ks_ready` does.
- R2: Key byte b is taken from `key_in[8b+7:8b]`, with byte 0 used first. `key_len` gives the key length in bytes. A value of 0 is treated as 1, and any value above 16 is treated as 16.
- R3: Table initialisation takes 128 cycles. In each cycle two entries are written: entry v gets v, and entry v+128 gets v+128.
- R4: For the published test keys the emitted bytes equal the RC4 keystream. For example, the key "Key" gives EB 9F 77 81 B7 34 CA 72.
- R5: The first keystream byte is presented (`ks_valid` high) exactly 645 clock edges after the edge that samples `key_load`. `ks_valid` stays low before that edge, even while `ks_ready` is high.
- R6: With `ks_ready` held high, one byte is accepted every two clock cycles.
- R7: While `ks_valid` is high and `ks_ready` is low, `ks_valid` and `ks_data` hold their values. No byte is lost or repeated, whatever the `ks_ready` pattern.
- R8: A `key_load` pulse at any time drops `ks_valid` on the next cycle. It discards the old stream and restarts from initialisation with the new key.
- R9: The output matches RC4 for random keys of every length from 1 to 16 bytes. This includes iterations where the two swap indices are equal, and iterations where the next read hits an entry written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_load | input | 1 | One-cycle strobe that captures the key and starts a new stream |
| key_in | input | 128 | Key bytes, byte b at bits 8b+7:8b |
| key_len | input | 5 | Key length in bytes, 1 to 16 (clamped) |
| ks_valid | output | 1 | Keystream byte available |
| ks_ready | input | 1 | Consumer accepts the byte when high together with `ks_valid` |
| ks_data | output | 8 | Keystream byte |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is in the generate step that fetches the next byte. There the consumer may take the held byte in the very cycle that the next byte is loaded. Holding `ks_ready` high forces this pairing on every byte, and a random `ks_ready` mixes it with stalls. Each stream is compared byte for byte with a behavioural model, so any loss or duplication shows up.

The second pair is the swap cycle. There the read of the next table entry can hit an address that is being written in the same cycle. Random keys of every length produce this case many times per stream, and the model comparison catches a stale read.

// File: rtl/rc4_keystream_core.sv
module rc4_keystream_core #(
  parameter int KEY_MAX = 16,
  localparam int LEN_W = $clog2(KEY_MAX + 1),
  localparam int KI_W  = $clog2(KEY_MAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_load,
  input  logic [8*KEY_MAX-1:0]   key_in,
  input  logic [LEN_W-1:0]       key_len,
  output logic                   ks_valid,
  input  logic                   ks_ready,
  output logic [7:0]             ks_data
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_MIX_PRE, ST_MIX_A, ST_MIX_B, ST_GEN_PRE, ST_GEN_A, ST_GEN_B
  } phase_t;

  phase_t st;
  logic [7:0] tbl [256];

  logic [6:0]           fill_n;
  logic [7:0]           i, j, k, si_d, rd_i, rd_j, hold;
  logic                 hold_full, have_k;
  logic [8*KEY_MAX-1:0] key_q;
  logic [KI_W-1:0]      kidx, klast;
  logic [LEN_W-1:0]     len_c;

  logic [7:0] key_b, jn, ip1;
  logic       swap_en, stall, take;

  assign len_c   = (key_len == '0) ? LEN_W'(1)
                 : (key_len > LEN_W'(KEY_MAX)) ? LEN_W'(KEY_MAX) : key_len;
  assign key_b   = key_q[kidx*8 +: 8];
  assign jn      = j + ((st == ST_MIX_A) ? key_b : 8'd0) + rd_i;
  assign ip1     = i + 8'd1;
  assign swap_en = (st == ST_MIX_B || st == ST_GEN_B) && (i != j);
  assign stall   = (st == ST_GEN_A) && have_k && hold_full && !ks_ready;
  assign take    = (st == ST_GEN_A) && have_k && !stall;

  assign ks_valid = hold_full;
  assign ks_data  = hold;

  // table writes: fill uses write-only and read/write ports, swap uses both
  always_ff @(posedge clk) begin
    if (st == ST_FILL) begin
      tbl[{1'b0, fill_n}] <= {1'b0, fill_n};
      tbl[{1'b1, fill_n}] <= {1'b1, fill_n};
    end else if (swap_en) begin
      tbl[i] <= rd_j;
      tbl[j] <= si_d;
    end
  end

  // synchronous reads, write-first bypass on the next-i read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_i <= '0;
      rd_j <= '0;
      hold <= '0;
    end else begin
      case (st)
        ST_MIX_PRE:           rd_i <= tbl[i];
        ST_MIX_B, ST_GEN_B:   rd_i <= (swap_en && ip1 == j) ? si_d : tbl[ip1];
        ST_GEN_PRE:           rd_i <= tbl[8'd1];
        default: ;
      endcase
      if (st == ST_MIX_A || (st == ST_GEN_A && !stall)) rd_j <= tbl[jn];
      if (take) hold <= tbl[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fill_n    <= '0;
      i         <= '0;
      j         <= '0;
      k         <= '0;
      si_d      <= '0;
      hold_full <= 1'b0;
      have_k    <= 1'b0;
      key_q     <= '0;
      kidx      <= '0;
      klast     <= '0;
    end else if (key_load) begin
      st        <= ST_FILL;
      fill_n    <= '0;
      hold_full <= 1'b0;
      have_k    <= 1'b0;
      key_q     <= key_in;
      klast     <= KI_W'(len_c - LEN_W'(1));
    end else begin
      if (take)          hold_full <= 1'b1;
      else if (ks_ready) hold_full <= 1'b0;
      case (st)
        ST_FILL: begin
          fill_n <= fill_n + 7'd1;
          if (fill_n == 7'd127) begin
            st   <= ST_MIX_PRE;
            i    <= '0;
            j    <= '0;
            kidx <= '0;
          end
        end
        ST_MIX_PRE: st <= ST_MIX_A;
        ST_MIX_A: begin
          j    <= jn;
          si_d <= rd_i;
          st   <= ST_MIX_B;
        end
        ST_MIX_B: begin
          i    <= ip1;
          kidx <= (kidx == klast) ? '0 : kidx + KI_W'(1);
          st   <= (i == 8'd255) ? ST_GEN_PRE : ST_MIX_A;
        end
        ST_GEN_PRE: begin
          i      <= 8'd1;
          j      <= '0;
          have_k <= 1'b0;
          st     <= ST_GEN_A;
        end
        ST_GEN_A: begin
          if (!stall) begin
            j    <= jn;
            si_d <= rd_i;
            st   <= ST_GEN_B;
          end
        end
        ST_GEN_B: begin
          k      <= si_d + rd_j;
          have_k <= 1'b1;
          i      <= ip1;
          st     <= ST_GEN_A;
        end
        default: ;
      endcase
    end
  end

  p_reload_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> !ks_valid);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready && !key_load) |=> (ks_valid && $stable(ks_data)));

  p_quiet_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {ST_IDLE, ST_FILL, ST_MIX_PRE, ST_MIX_A, ST_MIX_B, ST_GEN_PRE}) |-> !ks_valid);

  p_fill_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL && fill_n == 7'd127 && !key_load) |=> st == ST_MIX_PRE);

  p_two_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GEN_B && !key_load) |=> st == ST_GEN_A);

  p_mix_rounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MIX_B && i == 8'd255 && !key_load) |=> st == ST_GEN_PRE);

endmodule

// File: tb/rc4_keystream_core_bench.sv
module rc4_keystream_core_bench;
  logic clk = 1'b0, rst_n = 1'b0, key_load = 1'b0, ks_ready = 1'b0;
  logic [127:0] key_in = '0;
  logic [4:0]   key_len = 5'd1;
  logic         ks_valid;
  logic [7:0]   ks_data;

  int checks = 0, errors = 0;
  logic [7:0] got [256];
  logic [7:0] exp_b [256];

  always #2 clk = ~clk;

  rc4_keystream_core u_rc4_keystream_core (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .key_len(key_len), .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_data(ks_data));

  localparam int NV = 4;
  localparam logic [127:0] VKEY [NV] = '{128'h79654B, 128'h696B6957, 128'h746572636553, 128'h0504030201};
  localparam int           VLEN [NV] = '{3, 4, 6, 5};
  localparam int           VCNT [NV] = '{8, 6, 8, 8};
  localparam logic [63:0]  VEXP [NV] = '{64'hEB9F7781B734CA72, 64'h6044DB6D41B70000,
                                         64'h04D46B053CA87B59, 64'hB2396305F03DC027};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model(input logic [127:0] k, input int len, input int n);
    logic [7:0] s [256];
    logic [7:0] t, a, b;
    for (int v = 0; v < 256; v++) s[v] = 8'(v);
    b = 0;
    for (int v = 0; v < 256; v++) begin
      b = b + s[v] + k[(v % len)*8 +: 8];
      t = s[v]; s[v] = s[b]; s[b] = t;
    end
    a = 0; b = 0;
    for (int m = 0; m < n; m++) begin
      a = a + 1;
      b = b + s[a];
      t = s[a]; s[a] = s[b]; s[b] = t;
      exp_b[m] = s[8'(s[a] + s[b])];
    end
  endtask

  task automatic load(input logic [127:0] k, input int len);
    @(negedge clk);
    key_in = k; key_len = 5'(len); key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic recv(input int n, input bit rnd);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      ks_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (ks_valid && ks_ready) begin
        got[c] = ks_data;
        c++;
      end
    end
    @(negedge clk);
    ks_ready = 1'b0;
  endtask

  task automatic compare(input int n, input string req);
    for (int m = 0; m < n; m++)
      chk(got[m] == exp_b[m], req, got[m], exp_b[m]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int last;
    bit gap_ok;
    logic [7:0] held;
    logic [127:0] rk;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ks_valid == 1'b0, "R1 reset", ks_valid, 0);
    ks_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(ks_valid == 1'b0, "R1 idle with ready", ks_valid, 0);
    ks_ready = 1'b0;

    // R4: published vectors
    for (int v = 0; v < NV; v++) begin
      load(VKEY[v], VLEN[v]);
      recv(VCNT[v], 1'b0);
      for (int m = 0; m < VCNT[v]; m++)
        chk(got[m] == VEXP[v][63-8*m -: 8], "R4 vector", got[m], VEXP[v][63-8*m -: 8]);
    end

    // R5 first byte timing, R6 rate
    ks_ready = 1'b1;
    load(VKEY[0], 3);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ks_valid && cnt < 2000);
    chk(cnt == 645, "R5 first byte edge", cnt, 645);
    last = 0; gap_ok = 1'b1;
    for (int c = 1; c < 40; c++) begin
      @(negedge clk);
      if (ks_valid) begin
        if (c - last != 2) gap_ok = 1'b0;
        last = c;
      end
    end
    chk(gap_ok && last >= 38, "R6 two cycles per byte", last, 38);
    ks_ready = 1'b0;

    // R7 hold under stall
    load(VKEY[2], 6);
    model(VKEY[2], 6, 16);
    while (!ks_valid) @(negedge clk);
    held = ks_data;
    repeat (7) @(negedge clk);
    chk(ks_valid == 1'b1, "R7 valid held", ks_valid, 1);
    chk(ks_data == held, "R7 data held", ks_data, held);
    recv(16, 1'b1);
    compare(16, "R7 no loss under random ready");

    // R9 random keys of every length
    for (int len = 1; len <= 16; len++) begin
      rk = {$urandom, $urandom, $urandom, $urandom};
      load(rk, len);
      model(rk, len, 24);
      recv(24, 1'b1);
      compare(24, "R9 random key");
    end

    // R8 reload mid-stream
    load(VKEY[1], 4);
    recv(5, 1'b0);
    ks_ready = 1'b0;
    while (!ks_valid) @(negedge clk);
    rk = {$urandom, $urandom, $urandom, $urandom};
    load(rk, 9);
    chk(ks_valid == 1'b0, "R8 valid drops on reload", ks_valid, 0);
    model(rk, 9, 12);
    recv(12, 1'b1);
    compare(12, "R8 new stream after reload");

    // R2 length clamp
    rk = {$urandom, $urandom, $urandom, $urandom};
    load(rk, 0);
    model(rk, 1, 10);
    recv(10, 1'b0);
    compare(10, "R2 zero length as one");
    load(rk, 20);
    model(rk, 16, 10);
    recv(10, 1'b0);
    compare(10, "R2 long length as sixteen");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule